// File: doc/BRIEF.md
# Audio Transmit FIFO with Watermark and Underrun Handling

This block is the staging store between a software-side word write port and an audio frame serializer that pulls one word per slot. Words are kept in a small circular buffer addressed by read and write pointers, each one bit wider than the address so that a completely full buffer can be told apart from an empty one. Both pointers are visible at the ports.

Three status conditions come from the fill state. A request flag is raised while the number of stored words is at or below a programmable watermark, so that a feeder knows to add more. A warning flag is raised while the channel is enabled and the buffer is empty. A sticky error flag records an underrun, which is a serializer pull that finds nothing to send. Software clears the error by pulsing a write-one-to-clear input. After an underrun the serializer side is halted. In restart mode it stays halted until the error is cleared and the next frame begins. In replay mode it resumes as soon as data is present again, and the word that failed is the next word sent. A clear input empties the buffer without touching any setting. Separate enables combine the flags into one interrupt line and one DMA request line.

Top module: `tx_audio_fifo`

## Requirements
- R1: After reset both pointers read 0, the error flag is 0, the serializer side is active, and the request flag is 1 for any watermark.
- R2: A write while not full stores the word and advances the write pointer by one. A write while full (write pointer minus read pointer equals the depth, 32) is ignored and leaves the write pointer unchanged.
- R3: Words leave in write order. `rd_data` always shows the oldest stored word. `rd_ok` is 1 in a cycle where `rd_req` is accepted, and the read pointer then advances by one.
- R4: Pointers are 6 bits wide, with bit 5 used as a wrap bit. After 32 writes from a cleared state the write pointer reads 6'h20, and the 33rd write is rejected.
- R5: `req_flag` is 1 exactly when the stored count (write pointer minus read pointer, modulo 64) is less than or equal to `watermark`.
- R6: `warn_flag` is 1 exactly when `chan_en` is 1 and the buffer is empty.
- R7: An accepted-state `rd_req` on an empty buffer sets `err_flag` on the next edge. The flag holds until `err_clr` is pulsed. If a new underrun occurs in the same cycle as a clear, the flag stays set.
- R8: With `cont_on_err` = 0, an underrun drops `tx_active`. While halted, `rd_req` takes no word and does not move the read pointer. The block returns to active only on a `frame_start` seen after `err_flag` has been cleared.
- R9: With `cont_on_err` = 1, an underrun drops `tx_active`. The block becomes active again one edge after the buffer becomes non-empty, independent of `err_flag`, and the next word sent is the one written after the underrun.
- R10: `fifo_clr` sets both pointers to 0 on the next edge and leaves `err_flag` and all settings unchanged.
- R11: `irq` is the OR of (`req_flag` and `irq_req_en`), (`warn_flag` and `irq_warn_en`), and (`err_flag` and `irq_err_en`).
- R12: `dma_req` is the OR of (`req_flag` and `dma_req_en`) and (`warn_flag` and `dma_warn_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Channel enable, qualifies the warning flag |
| cont_on_err | input | 1 | 1 = replay the failed word; 0 = restart at the next frame |
| watermark | input | 5 | Request threshold in words |
| fifo_clr | input | 1 | Empties the buffer by zeroing both pointers |
| wr_en | input | 1 | Write strobe from software |
| wr_data | input | 32 | Word to write |
| rd_req | input | 1 | Serializer pulls one word |
| frame_start | input | 1 | Serializer frame boundary pulse |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| irq_req_en | input | 1 | Interrupt enable for the request flag |
| irq_warn_en | input | 1 | Interrupt enable for the warning flag |
| irq_err_en | input | 1 | Interrupt enable for the error flag |
| dma_req_en | input | 1 | DMA enable for the request flag |
| dma_warn_en | input | 1 | DMA enable for the warning flag |
| rd_data | output | 32 | Oldest stored word |
| rd_ok | output | 1 | The current pull is accepted |
| wr_ptr | output | 6 | Write pointer with wrap bit |
| rd_ptr | output | 6 | Read pointer with wrap bit |
| req_flag | output | 1 | Count at or below the watermark |
| warn_flag | output | 1 | Enabled and empty |
| err_flag | output | 1 | Sticky underrun |
| tx_active | output | 1 | Serializer side is running |
| irq | output | 1 | Gated interrupt |
| dma_req | output | 1 | Gated DMA request |

## Verification
The assertions check several rules on every cycle. The count never exceeds the depth. A write into a full buffer leaves the write pointer unchanged. A pull is accepted only when data is present. An underrun always sets the error flag, and the flag persists until it is cleared. A halted serializer side never takes a word, and a clear always zeroes the pointers. Some behaviours need a sequence of events, and only the bench scenarios show them. These are the exact resume point in each error mode, the set-wins-over-clear collision, the wrap-bit value after a full lap, the watermark boundary at equality, and the enable gating of the interrupt and DMA lines.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
    // Serializer-side flow states
    typedef enum logic [1:0] {
        FL_RUN        = 2'd0,
        FL_WAIT_CLEAR = 2'd1,
        FL_WAIT_FRAME = 2'd2,
        FL_WAIT_DATA  = 2'd3
    } flow_state_e;
endpackage

// File: rtl/tx_fifo_store.sv
// Circular word store with wrap-bit pointers.
// Assumes pop is only requested by the flow controller when not empty.
module tx_fifo_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W:0]   level,
    output logic              full,
    output logic              empty
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              push;

    // Fill state derived from pointer distance
    always_comb begin
        level = wr_ptr - rd_ptr;
        full  = (level == (ADDR_W+1)'(DEPTH));
        empty = (level == '0);
        push  = wr_en && !full && !clr;
        rd_data = mem[rd_ptr[ADDR_W-1:0]];
    end

    // Storage array write
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[ADDR_W-1:0]] <= wr_data;
    end

    // Pointer update with clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (ADDR_W+1)'(DEPTH));
    p_full_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !clr) |=> $stable(wr_ptr));
    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: rtl/tx_fifo_flow.sv
// Serializer-side flow control: accepts pulls, detects underrun and
// selects the resume point (next frame or same word).
// Assumes frame_start is a single-cycle pulse.
module tx_fifo_flow
    import tx_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cont_on_err,
    input  logic rd_req,
    input  logic empty,
    input  logic err_flag,
    input  logic frame_start,
    output logic pop,
    output logic underrun,
    output logic active
);
    flow_state_e state;

    // Accept or flag the current pull
    always_comb begin
        active   = (state == FL_RUN);
        pop      = active && rd_req && !empty;
        underrun = active && rd_req && empty;
    end

    // Halt and resume sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FL_RUN;
        end else begin
            unique case (state)
                FL_RUN:        if (underrun) state <= cont_on_err ? FL_WAIT_DATA : FL_WAIT_CLEAR;
                FL_WAIT_CLEAR: if (!err_flag) state <= FL_WAIT_FRAME;
                FL_WAIT_FRAME: if (frame_start) state <= FL_RUN;
                FL_WAIT_DATA:  if (!empty) state <= FL_RUN;
                default:       state <= FL_RUN;
            endcase
        end
    end

    p_halt_no_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FL_RUN) |-> !pop);
    p_halt_after_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> (state != FL_RUN));
endmodule

// File: rtl/tx_fifo_flags.sv
// Request, warning and sticky error flags plus enable gating.
// Assumes err_clr is a write-one pulse; a same-cycle underrun wins.
module tx_fifo_flags #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   level,
    input  logic              empty,
    input  logic [ADDR_W-1:0] watermark,
    input  logic              chan_en,
    input  logic              underrun,
    input  logic              err_clr,
    input  logic [2:0]        irq_en,
    input  logic [1:0]        dma_en,
    output logic              req_flag,
    output logic              warn_flag,
    output logic              err_flag,
    output logic              irq,
    output logic              dma_req
);
    // Level-based flags and output gating
    always_comb begin
        req_flag  = (level <= {1'b0, watermark});
        warn_flag = chan_en && empty;
        irq       = (req_flag && irq_en[0]) || (warn_flag && irq_en[1]) || (err_flag && irq_en[2]);
        dma_req   = (req_flag && dma_en[0]) || (warn_flag && dma_en[1]);
    end

    // Sticky underrun record, write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)         err_flag <= 1'b0;
        else if (underrun)  err_flag <= 1'b1;
        else if (err_clr)   err_flag <= 1'b0;
    end

    p_underrun_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> err_flag);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
endmodule

// File: rtl/tx_audio_fifo.sv
// Top level: audio transmit FIFO with watermark request, empty warning,
// sticky underrun error and selectable resume point.
// Assumes one writer and one serializer, both on clk.
module tx_audio_fifo #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              cont_on_err,
    input  logic [ADDR_W-1:0] watermark,
    input  logic              fifo_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              frame_start,
    input  logic              err_clr,
    input  logic              irq_req_en,
    input  logic              irq_warn_en,
    input  logic              irq_err_en,
    input  logic              dma_req_en,
    input  logic              dma_warn_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ok,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   rd_ptr,
    output logic              req_flag,
    output logic              warn_flag,
    output logic              err_flag,
    output logic              tx_active,
    output logic              irq,
    output logic              dma_req
);
    logic [ADDR_W:0] level;
    logic            full, empty, pop, underrun;

    tx_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
        .rd_data(rd_data), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .level(level), .full(full), .empty(empty)
    );

    tx_fifo_flow u_flow (
        .clk(clk), .rst_n(rst_n), .cont_on_err(cont_on_err),
        .rd_req(rd_req), .empty(empty), .err_flag(err_flag),
        .frame_start(frame_start), .pop(pop), .underrun(underrun),
        .active(tx_active)
    );

    tx_fifo_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .level(level), .empty(empty),
        .watermark(watermark), .chan_en(chan_en), .underrun(underrun),
        .err_clr(err_clr),
        .irq_en({irq_err_en, irq_warn_en, irq_req_en}),
        .dma_en({dma_warn_en, dma_req_en}),
        .req_flag(req_flag), .warn_flag(warn_flag), .err_flag(err_flag),
        .irq(irq), .dma_req(dma_req)
    );

    // Accepted pull indication
    assign rd_ok = pop;

    p_full_never_pushes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !fifo_clr) |=> (wr_ptr - rd_ptr) == (ADDR_W+1)'(1 << ADDR_W));
endmodule

// File: tb/tx_audio_fifo_bench.sv
module tx_audio_fifo_bench;
    logic        clk = 0, rst_n = 0;
    logic        chan_en = 1, cont_on_err = 0, fifo_clr = 0, wr_en = 0;
    logic        rd_req = 0, frame_start = 0, err_clr = 0;
    logic        irq_req_en = 0, irq_warn_en = 0, irq_err_en = 0;
    logic        dma_req_en = 0, dma_warn_en = 0;
    logic [4:0]  watermark = 5'd4;
    logic [31:0] wr_data = '0, rd_data;
    logic [5:0]  wr_ptr, rd_ptr;
    logic        rd_ok, req_flag, warn_flag, err_flag, tx_active, irq, dma_req;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    tx_audio_fifo u_tx_audio_fifo (.*);

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pull_expect(string rq, logic ok, logic [31:0] d);
        @(negedge clk); rd_req = 1; #1;
        chk(rq, rd_ok, ok);
        if (ok) chk(rq, rd_data, d);
        @(negedge clk); rd_req = 0;
    endtask

    task automatic clear();
        @(negedge clk); fifo_clr = 1;
        @(negedge clk); fifo_clr = 0;
    endtask

    task automatic t_reset();
        chk("R1 wr_ptr", wr_ptr, 0);
        chk("R1 rd_ptr", rd_ptr, 0);
        chk("R1 err", err_flag, 0);
        chk("R1 active", tx_active, 1);
        chk("R1 req", req_flag, 1);
        chk("R6 warn empty", warn_flag, 1);
    endtask

    task automatic t_order();
        push(32'hA1); push(32'hB2); push(32'hC3);
        chk("R2 wr_ptr", wr_ptr, 3);
        chk("R6 warn nonempty", warn_flag, 0);
        pull_expect("R3 first", 1, 32'hA1);
        chk("R3 rd_ptr", rd_ptr, 1);
        pull_expect("R3 second", 1, 32'hB2);
        pull_expect("R3 third", 1, 32'hC3);
        chk("R6 warn empty again", warn_flag, 1);
        @(negedge clk); chan_en = 0; #1;
        chk("R6 warn disabled", warn_flag, 0);
        chan_en = 1;
    endtask

    task automatic t_watermark();
        clear();
        for (int i = 0; i < 4; i++) push(i);
        chk("R5 level=wm", req_flag, 1);
        push(32'h55);
        chk("R5 level=wm+1", req_flag, 0);
        @(negedge clk); watermark = 5'd5; #1;
        chk("R5 raised wm", req_flag, 1);
        watermark = 5'd4;
    endtask

    task automatic t_full();
        clear();
        for (int i = 0; i < 32; i++) push(i);
        chk("R4 wrap bit", wr_ptr, 6'h20);
        push(32'h99);
        chk("R2 full ignored", wr_ptr, 6'h20);
        for (int i = 0; i < 32; i++) pull_expect("R3 full drain", 1, i);
        chk("R4 rd_ptr wrap", rd_ptr, 6'h20);
        push(32'h77);
        chk("R4 wr_ptr past wrap", wr_ptr, 6'h21);
        pull_expect("R2 dropped word absent", 1, 32'h77);
    endtask

    task automatic t_restart();
        clear();
        cont_on_err = 0;
        @(negedge clk); rd_req = 1; err_clr = 1;
        @(negedge clk); rd_req = 0; err_clr = 0;
        chk("R7 set wins over clear", err_flag, 1);
        chk("R8 halted", tx_active, 0);
        push(32'hD4);
        pull_expect("R8 no pop halted", 0, 0);
        chk("R8 rd_ptr held", rd_ptr, 0);
        step();
        chk("R7 sticky", err_flag, 1);
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        chk("R8 frame before clear ignored", tx_active, 0);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        chk("R7 w1c", err_flag, 0);
        step();
        chk("R8 waits frame", tx_active, 0);
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        chk("R8 resumed", tx_active, 1);
        pull_expect("R8 word after resume", 1, 32'hD4);
    endtask

    task automatic t_replay();
        clear();
        cont_on_err = 1;
        pull_expect("R9 underrun pull", 0, 0);
        chk("R9 halted", tx_active, 0);
        chk("R7 err set", err_flag, 1);
        push(32'hE5);
        step();
        chk("R9 resumed on data", tx_active, 1);
        chk("R9 err still set", err_flag, 1);
        pull_expect("R9 same slot word", 1, 32'hE5);
        cont_on_err = 0;
    endtask

    task automatic t_clr();
        push(1); push(2); push(3);
        clear();
        chk("R10 wr_ptr", wr_ptr, 0);
        chk("R10 rd_ptr", rd_ptr, 0);
        chk("R10 err kept", err_flag, 1);
        chk("R10 wm kept", req_flag, 1);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
    endtask

    task automatic t_gating();
        @(negedge clk); irq_err_en = 1; #1;
        chk("R11 err en, no err", irq, 0);
        irq_err_en = 0; irq_warn_en = 1; #1;
        chk("R11 warn gated", irq, 1);
        irq_warn_en = 0; irq_req_en = 1; #1;
        chk("R11 req gated", irq, 1);
        irq_req_en = 0; #1;
        chk("R11 all off", irq, 0);
        dma_req_en = 1; #1;
        chk("R12 req dma", dma_req, 1);
        for (int i = 0; i < 5; i++) push(i);
        chk("R12 req low", dma_req, 0);
        @(negedge clk); dma_warn_en = 1; #1;
        chk("R12 warn low nonempty", dma_req, 0);
        dma_req_en = 0; dma_warn_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_order();
        t_watermark();
        t_full();
        t_restart();
        t_replay();
        t_clr();
        t_gating();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule